// File: doc/BRIEF.md
# Single-Address DMA Engine with Boundary Pause

This block is the simple DMA engine inside an SD host controller. Software gives it a starting system address, a block length in bytes, a block count and a set of transfer-mode bits, and then issues a data command. The engine then moves 32-bit words between the controller's data-line buffer and a memory-side request port. In the card-to-memory direction it takes words from the buffer and writes them to memory. In the memory-to-card direction it reads memory and pushes the words into the buffer. After each accepted word the address advances by four.

Memory is split into windows whose size is a power of two: 4 KiB shifted left by a three-bit boundary code. When the next address lands on the start of a new window, the engine stops issuing requests and raises a boundary status bit. Software resumes the transfer by writing the address register. Reading the address register while paused returns exactly the address where the engine will go on, so writing that value back continues the transfer seamlessly. A separate status bit reports the end of the whole transfer. Both status bits are cleared by writing a one to them.

Register select codes on `cfgSel`:
- 0: system address
- 1: block length and boundary code
- 2: block count
- 3: transfer mode
- 4: command issue (write only)
- 5: interrupt status
- 6: status enable
- 7: host control

Top module: `sdma_engine`

## Requirements
- R1: After reset, every register reads zero and `memReq` is low.
- R2: Each register reads back what was last written. The address register returns 32 bits. Select 1 returns bits 14:0: the boundary code in bits 14:12 and the block length in bits 11:0. The block count returns bits 15:0. The mode returns bits 5:0, with bit 3 always zero. Host control returns its DMA-select field in bits 1:0. Status enable returns bits 1:0.
- R3: With mode bit 4 set (card to memory), each word taken from the buffer is written to memory at consecutive addresses, starting at the programmed address and stepping by 4.
- R4: With mode bit 4 clear (memory to card), each memory read returns a word that is handed to the buffer in the same cycle, with addresses stepping by 4.
- R5: A block occupies ceil(length/4) words. A length of zero counts as one word.
- R6: With mode bit 5 clear (single block), exactly one block moves and the block count register is left unchanged.
- R7: With mode bits 5 and 1 set, the block count decreases by one after each block, and the transfer ends when it reaches zero.
- R8: When the address after an accepted word is a multiple of 4096 shifted left by the boundary code, and the transfer is not finished, the engine stops requesting and sets status bit 1.
- R9: While paused, the address register reads the next address to be accessed. Writing the address register resumes the transfer from the written value.
- R10: Status bit 0 is set when the last word of the last block is accepted. A boundary that falls on that same word does not set bit 1.
- R11: Writing status with a bit at one clears that bit. A bit written as zero is kept.
- R12: A status bit is recorded only while the matching status-enable bit is set. Enabling it later does not expose an event that occurred while it was disabled.
- R13: A command issue is ignored if mode bit 0 (DMA enable) is clear, if the host-control DMA select is not 00, or if a counted multi-block transfer has a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register select |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Read data of the selected register |
| memReq | output | 1 | Memory request valid |
| memWrite | output | 1 | Request is a write (card to memory) |
| memAddr | output | ADDR_W | Byte address of the word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid in the cycle `memReady` is high |
| memReady | input | 1 | Memory accepts the request this cycle |
| bufInValid | input | 1 | Buffer holds a word received from the card |
| bufInData | input | 32 | Word received from the card |
| bufInReady | output | 1 | Engine takes the word this cycle |
| bufOutValid | output | 1 | Word for the card is valid this cycle |
| bufOutData | output | 32 | Word for the card |
| bufOutReady | input | 1 | Buffer has room for a word |

## Verification
The hardest situation to reach is a boundary crossing in the middle of a multi-block transfer, and above all one that falls exactly on the final word. In that case completion must win and no pause may appear.

The stimulus places start addresses a few words below a window edge and picks lengths and counts that make the crossing land inside a block, between blocks, or on the last word. Memory and buffer readiness are randomly throttled throughout. Each pause is resumed by writing back the address read from the engine. The number of pauses is compared with a count the bench derives from the start address and the total word count.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SIZE_W = 12;
  localparam int unsigned BND_W  = 3;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned MODE_W = 6;
  localparam int unsigned BASE_SHIFT = 12;

  typedef enum logic [2:0] {
    SelAddr   = 3'd0,
    SelSize   = 3'd1,
    SelCount  = 3'd2,
    SelMode   = 3'd3,
    SelGo     = 3'd4,
    SelStatus = 3'd5,
    SelStatEn = 3'd6,
    SelHost   = 3'd7
  } regSelE;

  typedef enum logic [1:0] {StIdle, StRun, StPause} stateE;

  typedef struct packed {
    logic incAddr;
    logic decCount;
    logic setDone;
    logic setBound;
  } strobeT;

  localparam int unsigned MODE_DMA_EN  = 0;
  localparam int unsigned MODE_CNT_EN  = 1;
  localparam int unsigned MODE_DIR_RD  = 4;
  localparam int unsigned MODE_MULTI   = 5;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  regSelE                cfgSel,
  input  logic [WORD_W-1:0]     cfgWdata,
  output logic [WORD_W-1:0]     cfgRdata,
  input  strobeT                strb,
  output logic [ADDR_W-1:0]     sysAddr,
  output logic [SIZE_W-1:0]     blkSize,
  output logic [BND_W-1:0]      bndCode,
  output logic [CNT_W-1:0]      blkCount,
  output logic [MODE_W-1:0]     modeBits,
  output logic [1:0]            dmaSel
);
  localparam int unsigned STAT_W = 2;

  logic [STAT_W-1:0] statBits;
  logic [STAT_W-1:0] statEn;
  logic              addrWr;
  logic              statWr;
  logic [STAT_W-1:0] setVec;

  assign addrWr = cfgWe && (cfgSel == SelAddr);
  assign statWr = cfgWe && (cfgSel == SelStatus);
  assign setVec = {strb.setBound, strb.setDone};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysAddr  <= '0;
      blkSize  <= '0;
      bndCode  <= '0;
      blkCount <= '0;
      modeBits <= '0;
      dmaSel   <= '0;
      statEn   <= '0;
    end else begin
      if (addrWr)
        sysAddr <= cfgWdata[ADDR_W-1:0];
      else if (strb.incAddr)
        sysAddr <= sysAddr + ADDR_W'(4);

      if (cfgWe && cfgSel == SelSize) begin
        blkSize <= cfgWdata[SIZE_W-1:0];
        bndCode <= cfgWdata[SIZE_W +: BND_W];
      end

      if (cfgWe && cfgSel == SelCount)
        blkCount <= cfgWdata[CNT_W-1:0];
      else if (strb.decCount)
        blkCount <= blkCount - CNT_W'(1);

      if (cfgWe && cfgSel == SelMode)
        modeBits <= cfgWdata[MODE_W-1:0] & 6'b110111;

      if (cfgWe && cfgSel == SelHost)
        dmaSel <= cfgWdata[1:0];

      if (cfgWe && cfgSel == SelStatEn)
        statEn <= cfgWdata[STAT_W-1:0];
    end
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rstN)
        statBits[b] <= 1'b0;
      else if (setVec[b] && statEn[b])
        statBits[b] <= 1'b1;
      else if (statWr && cfgWdata[b])
        statBits[b] <= 1'b0;
    end
  end

  always_comb begin
    cfgRdata = '0;
    unique case (cfgSel)
      SelAddr:   cfgRdata = WORD_W'(sysAddr);
      SelSize:   cfgRdata = WORD_W'({bndCode, blkSize});
      SelCount:  cfgRdata = WORD_W'(blkCount);
      SelMode:   cfgRdata = WORD_W'(modeBits);
      SelGo:     cfgRdata = '0;
      SelStatus: cfgRdata = WORD_W'(statBits);
      SelStatEn: cfgRdata = WORD_W'(statEn);
      SelHost:   cfgRdata = WORD_W'(dmaSel);
      default:   cfgRdata = '0;
    endcase
  end

  // R7: the count never steps below zero
  p_cnt_no_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.decCount |-> (blkCount != '0));

  // R6: single-block transfers never touch the count
  p_single_cnt_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.decCount |-> modeBits[MODE_MULTI]);

  // R3: each accepted word advances the address by one word
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incAddr && !addrWr) |=> (sysAddr == $past(sysAddr) + ADDR_W'(4)));

  // R11: a one written to bit 0 clears it unless a new event arrives
  p_w1c_r11: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && cfgWdata[0] && !strb.setDone) |=> !statBits[0]);
endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               goWr,
  input  logic               addrWr,
  input  logic [ADDR_W-1:0]  sysAddr,
  input  logic [SIZE_W-1:0]  blkSize,
  input  logic [BND_W-1:0]   bndCode,
  input  logic [CNT_W-1:0]   blkCount,
  input  logic [MODE_W-1:0]  modeBits,
  input  logic [1:0]         dmaSel,
  input  logic               memReady,
  input  logic               bufInValid,
  input  logic               bufOutReady,
  output strobeT             strb,
  output logic               memReq,
  output logic               memWrite,
  output logic               bufInReady,
  output logic               bufOutValid
);
  localparam int unsigned IDX_W = SIZE_W - 1;

  stateE              state;
  logic [IDX_W-1:0]   wordIdx;
  logic [SIZE_W:0]    sizePlus;
  logic [IDX_W-1:0]   sizeWords;
  logic [IDX_W-1:0]   lastIdx;
  logic [ADDR_W-1:0]  nextAddr;
  logic [ADDR_W-1:0]  bndSpan;
  logic [ADDR_W-1:0]  bndMask;
  logic               crossing;
  logic               dirRd;
  logic               multi;
  logic               cntEn;
  logic               canMove;
  logic               xfer;
  logic               lastWord;
  logic               finalBlk;
  logic               startOk;

  assign dirRd = modeBits[MODE_DIR_RD];
  assign multi = modeBits[MODE_MULTI];
  assign cntEn = modeBits[MODE_CNT_EN];

  assign sizePlus  = {1'b0, blkSize} + (SIZE_W+1)'(3);
  assign sizeWords = sizePlus[SIZE_W:2];
  assign lastIdx   = (sizeWords == '0) ? '0 : sizeWords - IDX_W'(1);

  assign nextAddr = sysAddr + ADDR_W'(4);
  assign bndSpan  = {{(ADDR_W-1){1'b0}}, 1'b1} << (BASE_SHIFT + int'(bndCode));
  assign bndMask  = bndSpan - ADDR_W'(1);
  assign crossing = (nextAddr & bndMask) == '0;

  assign canMove     = dirRd ? bufInValid : bufOutReady;
  assign memReq      = (state == StRun) && canMove;
  assign memWrite    = dirRd;
  assign xfer        = memReq && memReady;
  assign bufInReady  = xfer && dirRd;
  assign bufOutValid = xfer && !dirRd;

  assign lastWord = (wordIdx == lastIdx);
  assign finalBlk = !multi || (cntEn && blkCount == CNT_W'(1));
  assign startOk  = goWr && (state == StIdle) && modeBits[MODE_DMA_EN]
                    && (dmaSel == 2'b00) && !(multi && cntEn && blkCount == '0);

  always_comb begin
    strb = '0;
    if (xfer) begin
      strb.incAddr  = 1'b1;
      strb.decCount = lastWord && multi && cntEn;
      if (lastWord && finalBlk)
        strb.setDone = 1'b1;
      else if (crossing)
        strb.setBound = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= StIdle;
      wordIdx <= '0;
    end else begin
      unique case (state)
        StIdle: if (startOk) begin
          state   <= StRun;
          wordIdx <= '0;
        end
        StRun: if (xfer) begin
          wordIdx <= lastWord ? '0 : wordIdx + IDX_W'(1);
          if (strb.setDone)
            state <= StIdle;
          else if (strb.setBound)
            state <= StPause;
        end
        StPause: if (addrWr) state <= StRun;
        default: state <= StIdle;
      endcase
    end
  end

  // R8: no request in the cycle after a boundary stop
  p_pause_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBound |=> !memReq);

  // R10: completion and boundary never reported by the same word
  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setDone && strb.setBound));

  // R13: a command issue with DMA disabled starts nothing
  p_no_start_r13: assert property (@(posedge clk) disable iff (!rstN)
    (state == StIdle && goWr && !modeBits[MODE_DMA_EN]) |=> !memReq);
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memReady,
  input  logic              bufInValid,
  input  logic [31:0]       bufInData,
  output logic              bufInReady,
  output logic              bufOutValid,
  output logic [31:0]       bufOutData,
  input  logic              bufOutReady
);
  regSelE              selE;
  strobeT              strb;
  logic [ADDR_W-1:0]   sysAddr;
  logic [SIZE_W-1:0]   blkSize;
  logic [BND_W-1:0]    bndCode;
  logic [CNT_W-1:0]    blkCount;
  logic [MODE_W-1:0]   modeBits;
  logic [1:0]          dmaSel;
  logic                goWr;
  logic                addrWr;

  assign selE   = regSelE'(cfgSel);
  assign goWr   = cfgWe && (selE == SelGo);
  assign addrWr = cfgWe && (selE == SelAddr);

  sdma_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(selE),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .strb(strb),
    .sysAddr(sysAddr), .blkSize(blkSize), .bndCode(bndCode),
    .blkCount(blkCount), .modeBits(modeBits), .dmaSel(dmaSel)
  );

  sdma_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .goWr(goWr), .addrWr(addrWr),
    .sysAddr(sysAddr), .blkSize(blkSize), .bndCode(bndCode),
    .blkCount(blkCount), .modeBits(modeBits), .dmaSel(dmaSel),
    .memReady(memReady), .bufInValid(bufInValid), .bufOutReady(bufOutReady),
    .strb(strb), .memReq(memReq), .memWrite(memWrite),
    .bufInReady(bufInReady), .bufOutValid(bufOutValid)
  );

  assign memAddr    = sysAddr;
  assign memWdata   = bufInData;
  assign bufOutData = memRdata;
endmodule

// File: tb/test_sdma_engine.sv
`timescale 1ns/100ps
module test_sdma_engine;
  localparam logic [31:0] RD_KEY = 32'h5A5A_5A5A;
  localparam logic [31:0] IN_BASE = 32'hC0DE_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgSel = 3'd0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic memReq, memWrite, bufInReady, bufOutValid;
  logic [31:0] memAddr, memWdata, memRdata, bufOutData;
  logic memReady = 1'b0, bufInValid = 1'b0, bufOutReady = 1'b0;
  logic [31:0] bufInData;

  int checks = 0, errors = 0;
  bit rdyAll = 1'b0;
  int inIdx = 0;
  bit popPend = 1'b0;
  logic [31:0] expAddr = '0;
  int wordsSeen = 0, reqSeen = 0;
  bit monOn = 1'b0;

  always #2.5 clk = ~clk;

  assign memRdata  = memAddr ^ RD_KEY;
  assign bufInData = IN_BASE + 32'(inIdx);

  sdma_engine i_sdma_engine (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .bufInValid(bufInValid),
    .bufInData(bufInData), .bufInReady(bufInReady), .bufOutValid(bufOutValid),
    .bufOutData(bufOutData), .bufOutReady(bufOutReady)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int wordsOf(input int size);
    int w = (size + 3) / 4;
    return (w == 0) ? 1 : w;
  endfunction

  function automatic bit boundHit(input logic [31:0] a, input int code);
    logic [31:0] span = 32'd4096 << code;
    return (a & (span - 32'd1)) == 32'd0;
  endfunction

  // monitor: drive throttles at negedge, sample 0.5 ns before the edge
  always begin
    @(negedge clk);
    if (popPend) inIdx++;
    popPend = 1'b0;
    if (rdyAll) begin
      memReady = 1'b1; bufInValid = 1'b1; bufOutReady = 1'b1;
    end else begin
      memReady    = ($urandom % 4) != 0;
      bufInValid  = ($urandom % 3) != 0;
      bufOutReady = ($urandom % 3) != 0;
    end
    #2;
    if (memReq) reqSeen++;
    if (monOn && memReq && memReady) begin
      check(memAddr == expAddr, "R3 address", memAddr, expAddr);
      if (memWrite) begin
        check(memWdata == IN_BASE + 32'(inIdx), "R3 data", memWdata, IN_BASE + 32'(inIdx));
        check(bufInReady && !bufOutValid, "R3 pop", {30'd0, bufInReady, bufOutValid}, 32'd2);
        popPend = 1'b1;
      end else begin
        check(bufOutValid && bufOutData == (memAddr ^ RD_KEY), "R4 data",
              bufOutData, memAddr ^ RD_KEY);
      end
      expAddr += 32'd4;
      wordsSeen++;
    end
  end

  task automatic regWr(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 3'(sel); cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic regRd(input int sel, output logic [31:0] v);
    @(negedge clk);
    cfgSel = 3'(sel);
    #1 v = cfgRdata;
  endtask

  task automatic runXfer(input logic [31:0] a, input int size, input int code, input int cnt,
                         input bit rd, input bit multi, input string tag);
    int total, expPauses, pauses;
    logic [31:0] s, r;
    bit done;
    total = wordsOf(size) * (multi ? cnt : 1);
    expPauses = 0;
    for (int k = 1; k < total; k++)
      if (boundHit(a + 32'(4 * k), code)) expPauses++;
    regWr(0, a);
    regWr(1, {17'd0, 3'(code), 12'(size)});
    regWr(2, 32'(cnt));
    regWr(3, {26'd0, multi, rd, 2'b00, 1'b1, 1'b1});
    regWr(6, 32'd3);
    expAddr = a; wordsSeen = 0; pauses = 0; done = 1'b0;
    monOn = 1'b1;
    regWr(4, 32'd0);
    for (int t = 0; t < 20000 && !done; t++) begin
      regRd(5, s);
      if (s[1]) begin
        pauses++;
        regRd(0, r);
        check(r == expAddr, "R9 paused address readback", r, expAddr);
        check(boundHit(r, code), "R8 pause on window edge", r, expAddr);
        reqSeen = 0;
        repeat (3) @(negedge clk);
        check(reqSeen == 0, "R8 no request while paused", 32'(reqSeen), 32'd0);
        regWr(5, 32'd2);
        regWr(0, r);
      end else if (s[0]) begin
        done = 1'b1;
      end
    end
    check(done && s == 32'd1, {"R10 completion status ", tag}, s, 32'd1);
    check(wordsSeen == total, {"R5 word count ", tag}, 32'(wordsSeen), 32'(total));
    check(pauses == expPauses, {"R8 pause count ", tag}, 32'(pauses), 32'(expPauses));
    regRd(2, r);
    check(r == (multi ? 32'd0 : 32'(cnt)), multi ? "R7 count at end" : "R6 count unchanged",
          r, multi ? 32'd0 : 32'(cnt));
    monOn = 1'b0;
  endtask

  task automatic finishUp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    finishUp();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    for (int s = 0; s < 8; s++) begin
      regRd(s, v);
      check(v == 32'd0, "R1 register reset", v, 32'd0);
    end
    check(memReq == 1'b0, "R1 no request", {31'd0, memReq}, 32'd0);

    // R2 readback
    regWr(0, 32'h1234_5678); regRd(0, v); check(v == 32'h1234_5678, "R2 address", v, 32'h1234_5678);
    regWr(1, 32'hFFFF_7ABC); regRd(1, v); check(v == 32'h0000_7ABC, "R2 size", v, 32'h7ABC);
    regWr(2, 32'h1234_BEEF); regRd(2, v); check(v == 32'h0000_BEEF, "R2 count", v, 32'hBEEF);
    regWr(3, 32'hFFFF_FFFF); regRd(3, v); check(v == 32'h37, "R2 mode", v, 32'h37);
    regWr(7, 32'h0000_0002); regRd(7, v); check(v == 32'h2, "R2 host", v, 32'h2);
    regWr(6, 32'h0000_0003); regRd(6, v); check(v == 32'h3, "R2 enable", v, 32'h3);

    // R13 DMA select not 00 (mode currently has DMA enable set)
    regWr(2, 32'd1); reqSeen = 0; regWr(4, 0); repeat (10) @(negedge clk);
    check(reqSeen == 0, "R13 ignored for ADMA select", 32'(reqSeen), 0);
    regWr(7, 32'd0);
    // R13 DMA enable clear
    regWr(3, 32'h30); reqSeen = 0; regWr(4, 0); repeat (10) @(negedge clk);
    check(reqSeen == 0, "R13 ignored when DMA off", 32'(reqSeen), 0);
    // R13 counted multi-block with zero count
    regWr(2, 32'd0); regWr(3, 32'h33); reqSeen = 0; regWr(4, 0); repeat (10) @(negedge clk);
    check(reqSeen == 0, "R13 ignored with zero count", 32'(reqSeen), 0);
    regRd(5, v); check(v == 0, "R13 no status", v, 0);

    rdyAll = 1'b1;
    runXfer(32'h0000_1000, 16, 0, 5, 1'b0, 1'b0, "R4 R6 single mem-to-card");
    regWr(5, 3);
    runXfer(32'h0000_2000, 5, 0, 1, 1'b1, 1'b0, "R3 R5 odd length");
    regWr(5, 3);
    runXfer(32'h0000_3000, 0, 0, 1, 1'b1, 1'b0, "R5 zero length");
    regWr(5, 3);
    rdyAll = 1'b0;
    runXfer(32'h0000_4000, 12, 1, 3, 1'b1, 1'b1, "R7 multi");
    regWr(5, 3);
    runXfer(32'h0000_1FF8, 16, 0, 2, 1'b0, 1'b1, "R8 R9 mid-block edge");
    regWr(5, 3);
    runXfer(32'h0000_1FF0, 8, 0, 4, 1'b1, 1'b1, "R8 between blocks");
    regWr(5, 3);
    // R10 edge on the final word: completion only
    runXfer(32'h0000_2FF0, 16, 0, 1, 1'b0, 1'b0, "R10 edge on last word");

    // R11 write-one-to-clear, status currently 1
    regWr(5, 32'd0); regRd(5, v); check(v == 32'd1, "R11 zero write keeps", v, 32'd1);
    regWr(5, 32'd1); regRd(5, v); check(v == 32'd0, "R11 one write clears", v, 32'd0);

    // R12 status gating: disabled events are not latched
    rdyAll = 1'b1;
    regWr(0, 32'h0000_0FF8); regWr(1, 32'd16); regWr(3, 32'h01); regWr(6, 32'd0);
    monOn = 1'b1; expAddr = 32'h0FF8; wordsSeen = 0;
    regWr(4, 0); repeat (20) @(negedge clk);
    regRd(5, v); check(v == 32'd0, "R12 disabled boundary not shown", v, 32'd0);
    regRd(0, v); check(v == 32'h1000, "R12 R9 paused at edge", v, 32'h1000);
    regWr(6, 32'd3); regRd(5, v); check(v == 32'd0, "R12 late enable shows nothing", v, 32'd0);
    regWr(0, 32'h1000); repeat (20) @(negedge clk);
    check(wordsSeen == 4, "R12 transfer resumed and finished", 32'(wordsSeen), 32'd4);
    regRd(5, v); check(v == 32'd1, "R12 R10 enabled completion shown", v, 32'd1);
    regWr(5, 3); monOn = 1'b0;

    // random transfers around window edges
    rdyAll = 1'b0;
    for (int it = 0; it < 8; it++) begin
      int code, size, cnt;
      bit rd, multi;
      logic [31:0] a;
      code  = $urandom % 2;
      size  = 1 + $urandom % 40;
      cnt   = 1 + $urandom % 4;
      rd    = 1'($urandom % 2);
      multi = 1'($urandom % 2);
      a = (32'd4096 << code) * (1 + $urandom % 3) - 32'(4 * (1 + $urandom % 12));
      runXfer(a, size, code, cnt, rd, multi, "R3 R4 R8 random");
      regWr(5, 3);
    end
    // wide boundary code 7
    runXfer(32'h0008_0000 - 32'd8, 16, 7, 1, 1'b1, 1'b0, "R8 code seven");
    regWr(5, 3);
    finishUp();
  end
endmodule